// File: doc/BRIEF.md
# Sparse Ling Parallel-Prefix Adder

This block is a purely combinational 32-bit adder that adds two unsigned operands and returns a 32-bit sum and a carry-out. It has no carry-in. It does not ripple a true carry through every bit. Instead it carries Ling pseudo-carries through a parallel-prefix tree. Each bit has a generate term (AND of the operand bits), a transmit term (OR) and a half-sum (XOR). The operand bits are grouped in pairs, and each pair forms one pseudo-carry / transmit node. The prefix tree combines these nodes with an associative merge. As a result, only one group pseudo-carry exists for every second bit position.

Each pair computes two candidate sums in advance. One candidate assumes the incoming group pseudo-carry is 0 and the other assumes it is 1. In the second candidate, the true carry into the pair's lower bit is rebuilt from the transmit term of the bit just below the pair. A 2-to-1 selector driven by the prefix pseudo-carry of all lower pairs picks the final sum bits. The carry-out is the transmit of the most significant bit ANDed with the pseudo-carry of the whole word.

A parameter chooses between two tree shapes. The dense shape has full fan-in at every level. The fanout shape has one combine per group per level and uses wide broadcasts.

Top module: `ling_sparse_adder`

## Requirements
- R1: `sum` equals the low 32 bits of the unsigned sum `opa + opb` for every operand pair.
- R2: `cout` equals bit 32 of the unsigned sum `opa + opb`, treating both operands as zero-extended to 33 bits.
- R3: `sum[1:0]` depends only on `opa[1:0]` and `opb[1:0]`, because the lowest pair receives a pseudo-carry of 0. Changing any operand bit at position 2 or above leaves these two sum bits unchanged.
- R4: `cout` is 1 whenever `opa[31]` and `opb[31]` are both 1. `cout` is 0 whenever both are 0, whatever the lower bits hold.
- R5: A carry generated at bit 0 travels through all 32 positions when every higher position transmits. For example, `opa` = 32'hFFFF_FFFF and `opb` = 32'h0000_0001 give `sum` = 0 and `cout` = 1.
- R6: Both tree shapes give identical `sum` and `cout` for every operand pair. The shape is set by `TREE_KIND`, where 0 selects the dense shape and 1 selects the fanout shape.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First addend |
| opb | input | 32 | Second addend |
| sum | output | 32 | Low 32 bits of the sum |
| cout | output | 1 | Carry out of bit 31 |

## Verification
The bound checker evaluates the following properties every time the operands change:
- the full 33-bit result matches an arithmetic reference;
- the lowest pair's sum matches a 2-bit add;
- the top-bit generate and kill cases force `cout`;
- the prefix transmit of every group stays zero, since the word has no carry-in.

The bench scenarios cover what a single evaluation cannot show. One is that perturbing upper operand bits leaves the lowest pair untouched. Another is that a carry started at bit 0 survives the longest transmit chain. The last is that the dense and fanout tree shapes agree on the same inputs across directed corners and a long random run.

// File: rtl/ling_adder_pkg.sv
package ling_adder_pkg;

   // prefix tree shape selectors
   localparam int TREE_DENSE  = 0;
   localparam int TREE_FANOUT = 1;

   // pseudo-carry / transmit node
   typedef struct packed {
      logic h;
      logic t;
   } ling_pair_t;

   // associative merge: upper span absorbs lower span
   function automatic ling_pair_t ling_merge(input ling_pair_t upper, input ling_pair_t lower);
      ling_pair_t r;
      r.h = upper.h | (upper.t & lower.h);
      r.t = upper.t & lower.t;
      return r;
   endfunction

endpackage

// File: rtl/ling_group_form.sv
module ling_group_form
   import ling_adder_pkg::*;
(
   input  logic [1:0] a_pair,
   input  logic [1:0] b_pair,
   input  logic       t_below,
   output ling_pair_t node,
   output logic [1:0] sum_if0,
   output logic [1:0] sum_if1
);

   logic [1:0] gen_b;
   logic [1:0] trn_b;
   logic [1:0] hsum_b;
   logic       c_hi_if1;

   always_comb begin
      gen_b  = a_pair & b_pair;
      trn_b  = a_pair | b_pair;
      hsum_b = a_pair ^ b_pair;

      // pair pseudo-carry and pair transmit (shifted by one bit)
      node.h = gen_b[1] | gen_b[0];
      node.t = trn_b[0] & t_below;

      // incoming pseudo-carry 0: no carry into the lower bit
      sum_if0 = {hsum_b[1] ^ gen_b[0], hsum_b[0]};

      // incoming pseudo-carry 1: true carry into lower bit is t_below
      c_hi_if1 = gen_b[0] | (trn_b[0] & t_below);
      sum_if1  = {hsum_b[1] ^ c_hi_if1, hsum_b[0] ^ t_below};
   end

endmodule

// File: rtl/ling_prefix_tree.sv
module ling_prefix_tree
   import ling_adder_pkg::*;
#(
   parameter int NGRP      = 16,
   parameter int TREE_KIND = TREE_DENSE
) (
   input  logic [NGRP-1:0] h_in,
   input  logic [NGRP-1:0] t_in,
   output logic [NGRP-1:0] h_pfx,
   output logic [NGRP-1:0] t_pfx
);

   localparam int LEVELS = (NGRP > 1) ? $clog2(NGRP) : 1;

   if (NGRP < 2) begin : g_bad_ngrp
      $error("ling_prefix_tree: NGRP must be at least 2");
   end
   if (TREE_KIND != TREE_DENSE && TREE_KIND != TREE_FANOUT) begin : g_bad_kind
      $error("ling_prefix_tree: unknown TREE_KIND");
   end

   logic [NGRP-1:0] h_lv [LEVELS+1];
   logic [NGRP-1:0] t_lv [LEVELS+1];

   assign h_lv[0] = h_in;
   assign t_lv[0] = t_in;

   for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
      for (genvar i = 0; i < NGRP; i++) begin : g_node
         if (TREE_KIND == TREE_DENSE) begin : g_dense
            localparam int SPAN = 1 << lv;
            if (i >= SPAN) begin : g_merge
               assign {h_lv[lv+1][i], t_lv[lv+1][i]} =
                  ling_merge({h_lv[lv][i], t_lv[lv][i]},
                             {h_lv[lv][i-SPAN], t_lv[lv][i-SPAN]});
            end else begin : g_pass
               assign h_lv[lv+1][i] = h_lv[lv][i];
               assign t_lv[lv+1][i] = t_lv[lv][i];
            end
         end else begin : g_fanout
            localparam int SRC = ((i >> lv) << lv) - 1;
            if (((i >> lv) & 1) == 1) begin : g_merge
               assign {h_lv[lv+1][i], t_lv[lv+1][i]} =
                  ling_merge({h_lv[lv][i], t_lv[lv][i]},
                             {h_lv[lv][SRC], t_lv[lv][SRC]});
            end else begin : g_pass
               assign h_lv[lv+1][i] = h_lv[lv][i];
               assign t_lv[lv+1][i] = t_lv[lv][i];
            end
         end
      end
   end

   assign h_pfx = h_lv[LEVELS];
   assign t_pfx = t_lv[LEVELS];

endmodule

// File: rtl/ling_group_select.sv
module ling_group_select (
   input  logic       h_carry_in,
   input  logic [1:0] sum_if0,
   input  logic [1:0] sum_if1,
   output logic [1:0] sum_pair
);

   assign sum_pair = h_carry_in ? sum_if1 : sum_if0;

endmodule

// File: rtl/ling_sparse_adder.sv
module ling_sparse_adder
   import ling_adder_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int TREE_KIND = TREE_DENSE
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);

   localparam int NGRP = WIDTH / 2;

   if ((WIDTH % 2) != 0 || WIDTH < 4) begin : g_bad_width
      $error("ling_sparse_adder: WIDTH must be even and at least 4");
   end

   logic [WIDTH-1:0] trn_bit;
   logic [NGRP-1:0]  grp_h;
   logic [NGRP-1:0]  grp_t;
   logic [NGRP-1:0]  pfx_h;
   logic [NGRP-1:0]  pfx_t;

   assign trn_bit = opa | opb;

   for (genvar j = 0; j < NGRP; j++) begin : g_grp
      logic       t_below;
      logic       h_cin;
      ling_pair_t node;
      logic [1:0] cand0;
      logic [1:0] cand1;

      if (j == 0) begin : g_base
         // no carry-in: lowest pair sees pseudo-carry 0
         assign t_below = 1'b0;
         assign h_cin   = 1'b0;
      end else begin : g_upper
         assign t_below = trn_bit[2*j-1];
         assign h_cin   = pfx_h[j-1];
      end

      ling_group_form u_form (
         .a_pair  (opa[2*j+1:2*j]),
         .b_pair  (opb[2*j+1:2*j]),
         .t_below (t_below),
         .node    (node),
         .sum_if0 (cand0),
         .sum_if1 (cand1)
      );

      assign grp_h[j] = node.h;
      assign grp_t[j] = node.t;

      ling_group_select u_sel (
         .h_carry_in (h_cin),
         .sum_if0    (cand0),
         .sum_if1    (cand1),
         .sum_pair   (sum[2*j+1:2*j])
      );
   end

   ling_prefix_tree #(
      .NGRP      (NGRP),
      .TREE_KIND (TREE_KIND)
   ) u_tree (
      .h_in  (grp_h),
      .t_in  (grp_t),
      .h_pfx (pfx_h),
      .t_pfx (pfx_t)
   );

   assign cout = trn_bit[WIDTH-1] & pfx_h[NGRP-1];

endmodule

// File: rtl/ling_sparse_adder_chk.sv
module ling_sparse_adder_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0]   opa,
   input logic [WIDTH-1:0]   opb,
   input logic [WIDTH-1:0]   sum,
   input logic               cout,
   input logic [WIDTH/2-1:0] pfx_t
);

   logic [WIDTH:0] ref_full;
   logic [1:0]     ref_low;

   always_comb begin
      ref_full = {1'b0, opa} + {1'b0, opb};
      ref_low  = opa[1:0] + opb[1:0];
      if (!$isunknown({opa, opb})) begin
         // R1
         sum_match_chk: assert (sum == ref_full[WIDTH-1:0]);
         // R2
         carry_match_chk: assert (cout == ref_full[WIDTH]);
         // R3
         low_pair_chk: assert (sum[1:0] == ref_low);
         // R4
         cout_gen_chk: assert (!(opa[WIDTH-1] && opb[WIDTH-1]) || cout);
         // R4
         cout_kill_chk: assert (opa[WIDTH-1] || opb[WIDTH-1] || !cout);
         // R1
         prefix_transmit_chk: assert (pfx_t == '0);
      end
   end

endmodule

bind ling_sparse_adder ling_sparse_adder_chk #(.WIDTH(WIDTH)) u_ling_chk (
   .opa   (opa),
   .opb   (opb),
   .sum   (sum),
   .cout  (cout),
   .pfx_t (pfx_t)
);

// File: tb/test_ling_sparse_adder.sv
`timescale 1ns/1ps
module test_ling_sparse_adder;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] opa = '0;
   logic [W-1:0] opb = '0;
   logic [W-1:0] sum_d, sum_f;
   logic         cout_d, cout_f;

   int total = 0;
   int bad   = 0;
   bit reported = 1'b0;

   always #2 clk = ~clk;

   ling_sparse_adder #(.WIDTH(W), .TREE_KIND(0)) i_ling_sparse_adder (
      .opa (opa), .opb (opb), .sum (sum_d), .cout (cout_d)
   );

   ling_sparse_adder #(.WIDTH(W), .TREE_KIND(1)) i_ling_sparse_adder_fan (
      .opa (opa), .opb (opb), .sum (sum_f), .cout (cout_f)
   );

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
      end
   endtask

   // apply operands away from the clock edge and compare both shapes
   task automatic apply_check(input string tag, input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W:0] exp_full;
      @(negedge clk);
      opa = a;
      opb = b;
      #1;
      exp_full = {1'b0, a} + {1'b0, b};
      total++;
      if (sum_d !== exp_full[W-1:0] || cout_d !== exp_full[W]) begin
         bad++;
         $display("FAIL %s dense a=%h b=%h got=%b_%h exp=%b_%h",
                  tag, a, b, cout_d, sum_d, exp_full[W], exp_full[W-1:0]);
      end
      total++;
      if (sum_f !== sum_d || cout_f !== cout_d) begin
         bad++;
         $display("FAIL R6 shapes differ a=%h b=%h got=%b_%h exp=%b_%h",
                  a, b, cout_f, sum_f, cout_d, sum_d);
      end
   endtask

   task automatic t_reset_zero();
      // R1 R2: zero operands give zero result
      apply_check("R1/R2 zeros", '0, '0);
   endtask

   task automatic t_all_ones();
      apply_check("R1/R2 all ones", '1, '1);
      total++;
      if (sum_d !== 32'hFFFF_FFFE || cout_d !== 1'b1) begin
         bad++;
         $display("FAIL R2 all ones got=%b_%h exp=1_fffffffe", cout_d, sum_d);
      end
   endtask

   task automatic t_alternating();
      apply_check("R1 alt a+5", 32'hAAAA_AAAA, 32'h5555_5555);
      apply_check("R1 alt a+a", 32'hAAAA_AAAA, 32'hAAAA_AAAA);
      apply_check("R1 alt 5+5", 32'h5555_5555, 32'h5555_5555);
      apply_check("R1 alt cc+33", 32'hCCCC_CCCC, 32'h3333_3334);
   endtask

   task automatic t_chain();
      apply_check("R5 chain", 32'hFFFF_FFFF, 32'h0000_0001);
      total++;
      if (sum_d !== '0 || cout_d !== 1'b1) begin
         bad++;
         $display("FAIL R5 chain got=%b_%h exp=1_00000000", cout_d, sum_d);
      end
      // odd-bit start: generate at bit 1 through the rest
      apply_check("R5 chain odd", 32'hFFFF_FFFE, 32'h0000_0002);
      // transmit via OR of distinct operands, generate at bit 0
      apply_check("R5 chain split", 32'hF0F0_F0F1, 32'h0F0F_0F0F);
   endtask

   task automatic t_low_pair();
      logic [1:0] ref_bits;
      for (int lo = 0; lo < 16; lo++) begin
         logic [1:0] la = lo[1:0];
         logic [1:0] lb = lo[3:2];
         ref_bits = la + lb;
         for (int k = 0; k < 3; k++) begin
            logic [W-1:0] hi_a = $urandom() & 32'hFFFF_FFFC;
            logic [W-1:0] hi_b = (k == 0) ? 32'hFFFF_FFFC : ($urandom() & 32'hFFFF_FFFC);
            apply_check("R3 low pair", hi_a | {30'd0, la}, hi_b | {30'd0, lb});
            total++;
            if (sum_d[1:0] !== ref_bits) begin
               bad++;
               $display("FAIL R3 low pair got=%b exp=%b", sum_d[1:0], ref_bits);
            end
         end
      end
   endtask

   task automatic t_msb();
      apply_check("R4 msb gen", 32'h8000_0000, 32'h8000_0000);
      total++;
      if (cout_d !== 1'b1) begin
         bad++;
         $display("FAIL R4 msb gen got=%b exp=1", cout_d);
      end
      apply_check("R4 msb kill", 32'h7FFF_FFFF, 32'h7FFF_FFFF);
      total++;
      if (cout_d !== 1'b0) begin
         bad++;
         $display("FAIL R4 msb kill got=%b exp=0", cout_d);
      end
      apply_check("R4 msb prop", 32'h8000_0000, 32'h7FFF_FFFF);
      apply_check("R4 msb prop carry", 32'h8000_0001, 32'h7FFF_FFFF);
   endtask

   task automatic t_random();
      for (int n = 0; n < 100000; n++) begin
         apply_check("R1/R2/R6 random", $urandom(), $urandom());
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired got=timeout exp=finish");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_reset_zero();
      t_all_ones();
      t_alternating();
      t_chain();
      t_low_pair();
      t_msb();
      t_random();
      report();
      $finish;
   end

endmodule